// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with a pipelined read path and a late-write protocol. The address, select, global write enable and per-lane write enables are sampled on each rising clock edge. The data for a write is sampled one edge later. Read data leaves a registered output one edge after the edge that took the read address. Because write data trails its address by one cycle, a controller can move from reads to writes without an idle bus cycle.

Writes are posted. A write cycle records its address and lane mask in a holding buffer, and the following edge adds its data. The array is written only when the next write cycle arrives and pushes the held write out. Each read compares its address with the held one. On a match, lanes the held write enabled come from the buffer and the rest from the array, so a read always sees the most recent data. The data bus is modelled as a separate input, an output and a drive-enable. The output enable and a sleep input act on the drive-enable without waiting for a clock. After sleep falls, a parameterised number of recovery cycles are treated as deselects.

The default geometry is 1K words of four 9-bit lanes. Setting `ADDR_W`=15, `LANES`=4 gives a 32K x 36 organisation. Setting `ADDR_W`=16, `LANES`=2 gives a 64K x 18 organisation.

Top module: `lwsram_top`

## Requirements
- R1: A read is a cycle with `selN`=0 and `gwN`=1. If the previous cycle was not a read, `dOe` stays 0 after the edge that takes the read address. The read word is driven with `dOe`=1 after the following edge.
- R2: A write is a cycle with `selN`=0 and `gwN`=0. Its data is taken from `dIn` on the next rising edge, and later reads of that address return it.
- R3: A read of the address held by a pending write, issued in the cycle right after that write, returns the held data before it has reached the array.
- R4: When the held write enabled only some lanes and a read matches its address, the enabled lanes come from the held data and the others from the array.
- R5: A held write is committed to the array on the next write cycle. A later read of its address, after the buffer holds another address, returns the committed value.
- R6: Lane k covers `dIn`/`dOut` bits [9k+8:9k] and is enabled for writing by `bwN[k]`=0. Lanes whose `bwN` bit is 1 keep their old contents.
- R7: A cycle with `selN`=1 is a deselect. It writes nothing, even with `gwN`=0, and `dOe` is 0 after the following edge.
- R8: `oeN`=1 forces `dOe` to 0 at once, with no clock edge. Returning it to 0 restores the pending output word.
- R9: `sleep`=1 forces `dOe` to 0 at once, and the array contents survive sleep.
- R10: While `sleep`=1, and for `RECOV_CYC` (default 2) edges after it falls, every cycle is a deselect. Reads issued then produce no output, and writes issued then are discarded.
- R11: While `rstN`=0 and after its release, `dOe` is 0 and the holding buffer is empty. The first read after reset of an address written after reset returns that data.
- R12: Back-to-back writes to different addresses each land with their own data, whose `dIn` cycle overlaps the next write's address cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | Word address, sampled each edge |
| selN | input | 1 | Active-low synchronous select |
| gwN | input | 1 | Active-low global write enable |
| bwN | input | LANES | Active-low per-lane write enables |
| dIn | input | LANES*LANE_W | Write data, sampled one edge after its address |
| oeN | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Active-high asynchronous sleep |
| dOut | output | LANES*LANE_W | Read data, zero when not driven |
| dOe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach from the ports is a read that hits a partially written held word whose other lanes already sit in the array. The stimulus writes a full word, moves that word into the array by writing a second address, and then posts a two-lane write to the first address. It then reads that address at once, so the bypass has to merge lanes from both sources. The wake-up window needs similar care. A write and a read are placed exactly on the two recovery edges after sleep falls, and a read afterwards shows that neither took effect.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  // Strobes passed from the control unit to the datapath.
  typedef struct packed {
    logic loadBuf;   // write cycle: holding buffer takes address and mask
    logic commit;    // held write goes into the array this edge
    logic capData;   // late write data is on dIn this edge
    logic rdIssue;   // read cycle accepted: latch read address
    logic rdLoad;    // load output register from array/buffer merge
    logic outValid;  // output register holds a read word
    logic bufValid;  // holding buffer contains a write
  } ctlStrobes_t;

endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int RECOV_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        gwN,
  input  logic        sleep,
  output ctlStrobes_t st
);

  localparam int CNT_W = (RECOV_CYC < 1) ? 1 : $clog2(RECOV_CYC + 1);
  localparam logic [CNT_W-1:0] RECOV_LOAD = CNT_W'(RECOV_CYC);

  logic [CNT_W-1:0] recovCnt;
  logic dataPend;
  logic bufValid;
  logic rdPipe;
  logic outValid;

  logic blocked;
  logic cycWrite;
  logic cycRead;

  // Sleep and the wake-up window turn every cycle into a deselect.
  assign blocked  = sleep || (recovCnt != '0);
  assign cycWrite = !blocked && !selN && !gwN;
  assign cycRead  = !blocked && !selN && gwN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recovCnt <= '0;
      dataPend <= 1'b0;
      bufValid <= 1'b0;
      rdPipe   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (sleep) begin
        recovCnt <= RECOV_LOAD;
      end else if (recovCnt != '0) begin
        recovCnt <= recovCnt - 1'b1;
      end
      dataPend <= cycWrite;
      if (cycWrite) begin
        bufValid <= 1'b1;
      end
      rdPipe   <= cycRead;
      outValid <= rdPipe;
    end
  end

  always_comb begin
    st          = '0;
    st.loadBuf  = cycWrite;
    st.commit   = cycWrite && bufValid;
    st.capData  = dataPend;
    st.rdIssue  = cycRead;
    st.rdLoad   = rdPipe;
    st.outValid = outValid;
    st.bufValid = bufValid;
  end

endmodule

// File: rtl/lwsram_datapath.sv
module lwsram_datapath
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             st,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bwN,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOe
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] bufAddr;
  logic [LANES-1:0]  bufMask;
  logic [DATA_W-1:0] bufData;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] doutQ;

  logic [DATA_W-1:0] commitData;
  logic [DATA_W-1:0] arrayWord;
  logic [DATA_W-1:0] mergeWord;
  logic              addrHit;

  // If the held write's data arrives on this very edge, commit it straight from dIn.
  assign commitData = st.capData ? dIn : bufData;
  assign arrayWord  = mem[rdAddr];
  assign addrHit    = st.bufValid && (bufAddr == rdAddr);

  for (genvar l = 0; l < LANES; l++) begin : gMerge
    assign mergeWord[l*LANE_W +: LANE_W] =
      (addrHit && bufMask[l]) ? bufData[l*LANE_W +: LANE_W]
                              : arrayWord[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (st.commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (bufMask[l]) begin
          mem[bufAddr][l*LANE_W +: LANE_W] <= commitData[l*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufAddr <= '0;
      bufMask <= '0;
      bufData <= '0;
      rdAddr  <= '0;
      doutQ   <= '0;
    end else begin
      if (st.loadBuf) begin
        bufAddr <= addr;
        bufMask <= ~bwN;
      end
      if (st.capData) begin
        bufData <= dIn;
      end
      if (st.rdIssue) begin
        rdAddr <= addr;
      end
      if (st.rdLoad) begin
        doutQ <= mergeWord;
      end
    end
  end

  assign dOe  = st.outValid && !oeN && !sleep;
  assign dOut = dOe ? doutQ : '0;

endmodule

// File: rtl/lwsram_top.sv
module lwsram_top
  import lwsram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int RECOV_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    selN,
  input  logic                    gwN,
  input  logic [LANES-1:0]        bwN,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOe
);

  ctlStrobes_t strobes;

  lwsram_ctrl #(
    .RECOV_CYC(RECOV_CYC)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .selN (selN),
    .gwN  (gwN),
    .sleep(sleep),
    .st   (strobes)
  );

  lwsram_datapath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .st   (strobes),
    .addr (addr),
    .bwN  (bwN),
    .dIn  (dIn),
    .oeN  (oeN),
    .sleep(sleep),
    .dOut (dOut),
    .dOe  (dOe)
  );

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk
  import lwsram_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        selN,
  input logic        sleep,
  input logic        oeN,
  input logic        dOe,
  input ctlStrobes_t st
);

  // R1: an accepted read reaches the driven bus two edges later
  a_r1_read_pipeline: assert property (@(posedge clk) disable iff (!rstN)
    st.rdIssue |=> st.rdLoad ##1 (oeN || sleep || dOe));

  // R2: write data is taken on the edge after the write's address
  a_r2_late_data: assert property (@(posedge clk) disable iff (!rstN)
    st.loadBuf |=> st.capData);

  // R5: the array is only written on a write cycle
  a_r5_commit_on_write: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> st.loadBuf);

  // R7: a deselect starts neither a read nor a write
  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> (!st.rdIssue && !st.loadBuf));

  // R8: output enable high keeps the bus undriven
  a_r8_oe_float: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dOe);

  // R9: sleep keeps the bus undriven
  a_r9_sleep_float: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dOe);

  // R10: the first edge after sleep falls is still a deselect
  a_r10_wake_blocked: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleep) |-> (!st.rdIssue && !st.loadBuf));

  // R11: an empty buffer never commits
  a_r11_empty_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    !st.bufValid |-> !st.commit);

endmodule

bind lwsram_top lwsram_chk u_chk (
  .clk  (clk),
  .rstN (rstN),
  .selN (selN),
  .sleep(sleep),
  .oeN  (oeN),
  .dOe  (dOe),
  .st   (strobes)
);

// File: tb/lwsram_top_tb.sv
module lwsram_top_tb;

  localparam int AW    = 10;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          selN;
  logic          gwN;
  logic [LN-1:0] bwN;
  logic [DW-1:0] dIn;
  logic          oeN;
  logic          sleep;
  logic [DW-1:0] dOut;
  logic          dOe;

  int nChecks = 0;
  int nFail   = 0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] lateData = '0;

  always #10 clk = ~clk;

  lwsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .RECOV_CYC(2)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .gwN(gwN), .bwN(bwN),
    .dIn(dIn), .oeN(oeN), .sleep(sleep), .dOut(dOut), .dOe(dOe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each cycle task drives at a falling edge, including dIn for the previous write.
  task automatic cycWr(input logic [AW-1:0] a, input logic [LN-1:0] mask,
                       input logic [DW-1:0] d, input bit upd);
    dIn = lateData; selN = 1'b0; gwN = 1'b0; bwN = ~mask; addr = a;
    lateData = d;
    if (upd) begin
      for (int l = 0; l < LN; l++)
        if (mask[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
    end
    @(negedge clk);
  endtask

  task automatic cycRd(input logic [AW-1:0] a);
    dIn = lateData; selN = 1'b0; gwN = 1'b1; bwN = '1; addr = a;
    lateData = '0;
    @(negedge clk);
  endtask

  task automatic cycNop();
    dIn = lateData; selN = 1'b1; gwN = 1'b1; bwN = '1;
    lateData = '0;
    @(negedge clk);
  endtask

  task automatic rdCheck(input logic [AW-1:0] a, input string tag);
    cycRd(a);
    cycNop();
    chk({tag, " dOe"}, 64'(dOe), 64'd1);
    chk({tag, " data"}, 64'(dOut), 64'(model[a]));
  endtask

  task automatic testReset();
    chk("R11 dOe after reset", 64'(dOe), 64'd0);
    cycWr(10'h005, 4'hF, 36'h1_2345_6789, 1'b1);
    cycNop();
    cycWr(10'h006, 4'hF, 36'h0_0000_0000, 1'b1);
    cycNop();
    rdCheck(10'h005, "R11 first read");
  endtask

  task automatic testBasic();
    cycWr(10'h010, 4'hF, 36'hA_BCDE_F012, 1'b1);
    cycWr(10'h011, 4'hF, 36'h3_4567_89AB, 1'b1);
    cycNop();
    cycRd(10'h010);
    chk("R1 not yet driven", 64'(dOe), 64'd0);
    cycRd(10'h011);
    chk("R1 first word", 64'(dOut), 64'(model[10'h010]));
    chk("R2 first word dOe", 64'(dOe), 64'd1);
    cycNop();
    chk("R2 second word", 64'(dOut), 64'(model[10'h011]));
  endtask

  task automatic testBypass();
    cycWr(10'h020, 4'hF, 36'h5_A5A5_A5A5, 1'b1);
    rdCheck(10'h020, "R3 full bypass");
  endtask

  task automatic testMerge();
    logic [DW-1:0] exp;
    cycWr(10'h030, 4'hF, {9'h1A1, 9'h1B2, 9'h1C3, 9'h1D4}, 1'b1);
    cycWr(10'h031, 4'hF, 36'h0_1111_2222, 1'b1);
    cycNop();
    cycWr(10'h030, 4'b0101, {9'h055, 9'h066, 9'h077, 9'h088}, 1'b1);
    exp = {9'h1A1, 9'h066, 9'h1C3, 9'h088};
    cycRd(10'h030);
    cycNop();
    chk("R4 merged word", 64'(dOut), 64'(exp));
    chk("R6 lane mapping model", 64'(model[10'h030]), 64'(exp));
    // R5: push the partial write into the array, then read it back from there
    cycWr(10'h032, 4'hF, 36'h7_7777_7777, 1'b1);
    cycNop();
    rdCheck(10'h030, "R5 committed word");
    rdCheck(10'h032, "R5 new held word");
  endtask

  task automatic testBackToBack();
    cycWr(10'h040, 4'hF, 36'h0_0000_0040, 1'b1);
    cycWr(10'h041, 4'hF, 36'h1_0000_0041, 1'b1);
    cycWr(10'h042, 4'hF, 36'h2_0000_0042, 1'b1);
    cycWr(10'h043, 4'b1000, 36'hF_FFFF_FFFF, 1'b1);
    cycNop();
    rdCheck(10'h040, "R12 word 0");
    rdCheck(10'h041, "R12 word 1");
    rdCheck(10'h042, "R12 word 2");
  endtask

  task automatic testDeselect();
    dIn = lateData; selN = 1'b1; gwN = 1'b0; bwN = '0; addr = 10'h040;
    lateData = 36'hD_EADD_EADD;
    @(negedge clk);
    cycNop();
    rdCheck(10'h040, "R7 deselected write ignored");
    cycNop();
    chk("R7 dOe after deselect", 64'(dOe), 64'd0);
  endtask

  task automatic testOe();
    rdCheck(10'h041, "R8 setup");
    oeN = 1'b1;
    #2;
    chk("R8 oeN float", 64'(dOe), 64'd0);
    oeN = 1'b0;
    #2;
    chk("R8 oeN restore", 64'(dOut), 64'(model[10'h041]));
  endtask

  task automatic testSleep();
    rdCheck(10'h042, "R9 setup");
    sleep = 1'b1;
    #2;
    chk("R9 sleep float", 64'(dOe), 64'd0);
    cycWr(10'h042, 4'hF, 36'h9_9999_9999, 1'b0);
    cycRd(10'h042);
    cycNop();
    chk("R9 no drive while asleep", 64'(dOe), 64'd0);
    sleep = 1'b0;
    cycWr(10'h042, 4'hF, 36'h6_6666_6666, 1'b0);
    cycRd(10'h042);
    cycNop();
    chk("R10 recovery read dropped", 64'(dOe), 64'd0);
    rdCheck(10'h042, "R10 recovery write dropped");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; addr = '0; selN = 1'b1; gwN = 1'b1; bwN = '1; dIn = '0;
    oeN = 1'b0; sleep = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 dOe in reset", 64'(dOe), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testBypass();
    testMerge();
    testBackToBack();
    testDeselect();
    testOe();
    testSleep();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule